// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a simple on-chip request port to an external asynchronous static RAM of 256K words by 32 bits. A requester presents a read or a write with an 18-bit word address, 32-bit write data and a 4-bit byte-lane mask. A valid/ready handshake transfers it, and the controller accepts a request only while it is idle. The controller then steps the memory pins through a read or a write cycle. It drives a registered address, four active-low byte chip selects, an active-low write strobe, an active-low output enable and a shared tristate data bus. Read data returns through a one-cycle response pulse.

Every interval of a memory cycle is a whole number of system clocks, and a parameter sets each count. A read enables all four lanes with the output enable low, and it samples the bus when the access count ends. A write is strobe-controlled. It enables only the masked-in lanes, lowers the write strobe after the setup count and raises it after the pulse count. It then keeps the address and data on the pins for the hold count. The output enable stays high for the whole write, so the pulse never needs to be stretched to cover the memory turning its drivers off.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, mem_we_n, mem_oe_n and all of mem_cs_n are 1, rsp_valid is 0 and req_ready is 1. A reset in the middle of a cycle returns the pins to that state after one clock edge.
- R2: req_ready is 1 only while the controller is idle. A request held valid while a cycle is in progress is not taken, and it does not disturb mem_addr until the current cycle ends.
- R3: A read sets mem_cs_n to 4'b0000, mem_oe_n to 0 and mem_we_n to 1 for RD_ACCESS_CYC cycles after the accepting edge. rsp_valid is then 1 for exactly one cycle, starting RD_ACCESS_CYC edges after the accepting edge, and rsp_rdata holds the word stored at that address. The strobes are high again in that cycle.
- R4: A write spends WR_SETUP_CYC cycles with the selected chip selects low and mem_we_n high. It then spends WR_PULSE_CYC cycles with mem_we_n low, then WR_HOLD_CYC cycles with every strobe high. req_ready returns WR_SETUP_CYC+WR_PULSE_CYC+WR_HOLD_CYC edges after the accepting edge.
- R5: Bit i of req_mask selects byte lane i, which is data bits [8i+7:8i] and mem_cs_n[i]. During a write, mem_cs_n[i] is low only for selected lanes. Unselected lanes keep their old contents, and a mask of 4'b0000 changes no stored byte.
- R6: mem_addr changes only while mem_we_n is high. It stays unchanged while mem_we_n is low and in the cycle after mem_we_n rises. The chip selects are already settled when mem_we_n falls.
- R7: mem_oe_n stays 1 for every cycle of a write, so mem_oe_n and mem_we_n are never low together.
- R8: The controller drives the write data on mem_dq from the falling edge of mem_we_n through the hold cycles. At all other times it releases the bus, so a read right after a write returns the memory's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte-lane select for writes, bit i = lane i |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 32 | Read data |
| mem_addr | output | 18 | Memory address bus |
| mem_cs_n | output | 4 | Active-low byte-lane chip selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | 32 | Bidirectional memory data bus |

## Verification
The properties assume the requester holds req_addr, req_write, req_wdata and req_mask steady while req_valid is high. They also assume that nothing else drives the memory pins. The bench changes request inputs only at falling clock edges and keeps them fixed until the accepting edge. It holds a second request valid through a busy write to exercise the wait. The memory model drives the bus only while its output enable is low and the write strobe is high. The model also counts any address change during a write overlap and any overlap of the two strobes.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the asynchronous SRAM bus controller.
// Assumes: all cycle counts handed to cyc_max4 are at least 1.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_END,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_e;

    // Largest of four interval counts, used to size the interval counter.
    function automatic int cyc_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Interval counter for one memory cycle phase.
// It loads (length-1) when a phase starts and counts down to zero.
// expired is high in the last cycle of the phase.
// Assumes: load_val fits in CNT_W bits.
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load at phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
// Cycle sequencer for the SRAM controller.
// It picks the next phase and registers each strobe from the next-state value,
// so the strobe pins change only at clock edges and never glitch.
// Assumes: every cycle-count parameter is at least 1.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_ACCESS_CYC = 2,
    parameter int WR_SETUP_CYC  = 1,
    parameter int WR_PULSE_CYC  = 1,
    parameter int WR_HOLD_CYC   = 1,
    parameter int CNT_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cs_on_nxt,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_drive,
    output logic             rsp_valid
);

    localparam logic [CNT_W-1:0] LD_RD = CNT_W'(RD_ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WS = CNT_W'(WR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WP = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WH = CNT_W'(WR_HOLD_CYC - 1);

    ctl_state_e state_q, state_n;

    // Next-phase choice and interval counter reload.
    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_n = ST_WR_SETUP;
                        tmr_val = LD_WS;
                    end else begin
                        state_n = ST_RD_ACC;
                        tmr_val = LD_RD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) state_n = ST_RD_END;
            end
            ST_RD_END: begin
                state_n = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_n  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WP;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_n  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WH;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign capture   = (state_q == ST_RD_ACC) && tmr_expired;
    assign cs_on_nxt = (state_n == ST_RD_ACC) || (state_n == ST_WR_SETUP) ||
                       (state_n == ST_WR_PULSE);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Strobes and the response pulse, registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            dq_drive  <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            we_n      <= (state_n != ST_WR_PULSE);
            oe_n      <= (state_n != ST_RD_ACC);
            dq_drive  <= (state_n == ST_WR_PULSE) || (state_n == ST_WR_HOLD);
            rsp_valid <= (state_n == ST_RD_END);
        end
    end

endmodule

// File: rtl/sram_ctl_io.sv
// Pin-side registers: the address, the write data, per-lane chip selects
// and the read-data capture register.
// Assumes: accept comes only from the idle phase, and capture marks the
// final access cycle of a read.
module sram_ctl_io #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic              cs_on_nxt,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_cs_n,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [LANES-1:0] lane_q;
    logic [LANES-1:0] lane_nxt;
    logic [LANES-1:0] cs_n_nxt;

    // Per-lane enable for the coming cycle: all lanes on a read, masked lanes on a write.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_nxt[l] = accept ? (req_write ? req_mask[l] : 1'b1) : lane_q[l];
        assign cs_n_nxt[l] = ~(cs_on_nxt & lane_nxt[l]);
    end

    // Request capture: lane set, address and write data held for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q   <= '0;
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            lane_q   <= lane_nxt;
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
        end
    end

    // Registered chip selects.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_cs_n <= '1;
        else        mem_cs_n <= cs_n_nxt;
    end

    // Read data sampled when the access count ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (capture) rsp_rdata <= mem_dq_in;
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
// Asynchronous SRAM bus controller, top level.
// It accepts one request at a time from a valid/ready port and runs a
// clock-counted read or strobe-controlled write on the memory pins.
// Assumes: request fields are steady while req_valid is high, and each
// cycle count is at least 1.
module sram_bus_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 32,
    parameter int RD_ACCESS_CYC = 2,
    parameter int WR_SETUP_CYC  = 1,
    parameter int WR_PULSE_CYC  = 1,
    parameter int WR_HOLD_CYC   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_cs_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    inout  wire  [DATA_W-1:0]   mem_dq
);

    localparam int LANES   = DATA_W / 8;
    localparam int MAX_CYC = cyc_max4(RD_ACCESS_CYC, WR_SETUP_CYC, WR_PULSE_CYC, WR_HOLD_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cs_on_nxt;
    logic             dq_drive;
    logic [DATA_W-1:0] dq_out;

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_fsm #(
        .RD_ACCESS_CYC (RD_ACCESS_CYC),
        .WR_SETUP_CYC  (WR_SETUP_CYC),
        .WR_PULSE_CYC  (WR_PULSE_CYC),
        .WR_HOLD_CYC   (WR_HOLD_CYC),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cs_on_nxt   (cs_on_nxt),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .dq_drive    (dq_drive),
        .rsp_valid   (rsp_valid)
    );

    sram_ctl_io #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .cs_on_nxt (cs_on_nxt),
        .capture   (capture),
        .mem_dq_in (mem_dq),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .dq_out    (dq_out),
        .rsp_rdata (rsp_rdata)
    );

    // Data bus driver: write data only while the driver enable register is set.
    assign mem_dq = dq_drive ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker for the SRAM bus controller, bound to the top module.
// It watches only the top-level ports and counts write-strobe low time itself.
// Assumes: the request fields are steady while req_valid is high.
module sram_bus_ctrl_chk #(
    parameter int ADDR_W       = 18,
    parameter int DATA_W       = 32,
    parameter int WR_PULSE_CYC = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_cs_n,
    input logic                mem_we_n,
    input logic                mem_oe_n
);

    localparam int WL_W = $clog2(WR_PULSE_CYC + 2);

    logic [WL_W-1:0] we_low_cnt;

    // Length of the current write-strobe low stretch, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_cnt <= '0;
        else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else                we_low_cnt <= '0;
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_we_n && mem_oe_n && (&mem_cs_n)));

    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_after_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n && (&mem_cs_n)));

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == WL_W'(WR_PULSE_CYC)));

    assert_we_fall_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_cs_n)));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || $past(!mem_we_n)) |-> $stable(mem_addr));

    assert_no_oe_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .WR_PULSE_CYC (WR_PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/sram_async_model.sv
// Behavioural asynchronous SRAM with byte-lane selects.
// A lane is written when its chip-select/write-strobe overlap ends.
// It counts address changes during an overlap and any overlap of the two strobes.
module sram_async_model #(
    parameter int AW = 18,
    parameter int DW = 32
) (
    input  logic            en,
    input  logic [AW-1:0]   addr,
    input  logic [DW/8-1:0] cs_n,
    input  logic            we_n,
    input  logic            oe_n,
    inout  wire  [DW-1:0]   dq,
    output int              viol
);
    localparam int NL = DW / 8;

    logic [DW-1:0] mem [bit [AW-1:0]];
    logic [DW-1:0] rd_word = '0;
    logic [NL-1:0] wact;
    logic [NL-1:0] wact_prev = '0;
    logic [AW-1:0] prev_addr = '0;
    logic [NL-1:0] rd_on;
    int            viol_q = 0;

    assign viol = viol_q;

    // Strobe and address watcher: rule checks, lane writes, read word lookup.
    always @(addr, cs_n, we_n, oe_n) begin
        logic [DW-1:0] w;
        wact = {NL{~we_n}} & ~cs_n;
        if (en) begin
            if ((addr != prev_addr) && ((wact_prev != '0) || (wact != '0))) viol_q++;
            if (!we_n && !oe_n) viol_q++;
            w = mem.exists(prev_addr) ? mem[prev_addr] : '0;
            for (int l = 0; l < NL; l++) begin
                if (wact_prev[l] && !wact[l]) w[l*8 +: 8] = dq[l*8 +: 8];
            end
            if ((wact_prev & ~wact) != '0) mem[prev_addr] = w;
        end
        rd_word   = mem.exists(addr) ? mem[addr] : '0;
        prev_addr = addr;
        wact_prev = wact;
    end

    for (genvar l = 0; l < NL; l++) begin : g_rd
        assign rd_on[l] = en & ~oe_n & we_n & ~cs_n[l];
        assign dq[l*8 +: 8] = rd_on[l] ? rd_word[l*8 +: 8] : 8'bz;
    end

endmodule

// File: tb/sim_sram_bus_ctrl.sv
// Self-checking bench for sram_bus_ctrl: a vector table, then directed tests.
module sim_sram_bus_ctrl;

    localparam int AW = 18;
    localparam int DW = 32;
    localparam int NL = DW / 8;
    localparam int RD = 2;
    localparam int WS = 1;
    localparam int WP = 1;
    localparam int WH = 1;
    localparam int NVEC = 12;

    // Vector fields: {write, addr[17:0], data[31:0], mask[3:0]}
    localparam logic [54:0] VEC [NVEC] = '{
        {1'b1, 18'h00000, 32'hDEADBEEF, 4'hF},
        {1'b1, 18'h3FFFF, 32'h01234567, 4'hF},
        {1'b0, 18'h00000, 32'h0,        4'h0},
        {1'b0, 18'h3FFFF, 32'h0,        4'h0},
        {1'b1, 18'h00000, 32'hAABBCCDD, 4'h1},
        {1'b0, 18'h00000, 32'h0,        4'h0},
        {1'b1, 18'h00000, 32'h11223344, 4'hA},
        {1'b0, 18'h00000, 32'h0,        4'h0},
        {1'b1, 18'h15555, 32'hCAFEF00D, 4'h0},
        {1'b0, 18'h15555, 32'h0,        4'h0},
        {1'b1, 18'h2AAAA, 32'h5A5AA5A5, 4'hC},
        {1'b0, 18'h2AAAA, 32'h0,        4'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NL-1:0] req_mask = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [NL-1:0] mem_cs_n;
    logic          mem_we_n;
    logic          mem_oe_n;
    wire  [DW-1:0] mem_dq;
    int            viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] refm [bit [AW-1:0]];

    always #5 clk = ~clk;

    sram_bus_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_ACCESS_CYC(RD),
        .WR_SETUP_CYC(WS), .WR_PULSE_CYC(WP), .WR_HOLD_CYC(WH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    sram_async_model #(.AW(AW), .DW(DW)) u_mem (
        .en(rst_n), .addr(mem_addr), .cs_n(mem_cs_n), .we_n(mem_we_n),
        .oe_n(mem_oe_n), .dq(mem_dq), .viol(viol)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
        return refm.exists(a) ? refm[a] : '0;
    endfunction

    // Present a request at a falling edge and return at the falling edge after acceptance.
    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [NL-1:0] m);
        req_write = w; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [NL-1:0] m, input bit ovl, input logic [AW-1:0] oa);
        bit seq_ok = 1, addr_ok = 1, oe_ok = 1, bus_ok = 1, rdy_ok = 1;
        int we_low = 0;
        issue(1'b1, a, d, m);
        for (int n = 1; n <= WS + WP + WH; n++) begin
            if (n <= WS) begin
                if (mem_cs_n !== ~m || mem_we_n !== 1'b1) seq_ok = 0;
            end else if (n <= WS + WP) begin
                if (mem_cs_n !== ~m || mem_we_n !== 1'b0) seq_ok = 0;
                if (mem_dq !== d) bus_ok = 0;
            end else begin
                if (mem_cs_n !== '1 || mem_we_n !== 1'b1) seq_ok = 0;
                if (mem_dq !== d) bus_ok = 0;
            end
            if (!mem_we_n) we_low++;
            if (mem_oe_n !== 1'b1) oe_ok = 0;
            if (mem_addr !== a) addr_ok = 0;
            if (req_ready !== 1'b0) rdy_ok = 0;
            if (ovl && n == 1) begin
                req_write = 1'b0; req_addr = oa; req_valid = 1'b1;
            end
            @(negedge clk);
        end
        check(seq_ok && req_ready && mem_we_n && (&mem_cs_n), "R4", "write phase sequence",
              {63'd0, seq_ok}, 64'd1);
        check(we_low == WP, "R4", "write strobe low cycles", 64'(we_low), 64'(WP));
        check(seq_ok, "R5", "lane selects follow mask", {60'd0, m}, {60'd0, m});
        check(addr_ok, "R6", "address held through write", 64'(mem_addr), 64'(a));
        check(oe_ok, "R7", "output enable high in write", {63'd0, oe_ok}, 64'd1);
        check(bus_ok, "R8", "write data on bus", {32'd0, mem_dq}, {32'd0, d});
        if (ovl) check(rdy_ok, "R2", "ready low while busy", {63'd0, rdy_ok}, 64'd1);
        for (int l = 0; l < NL; l++) begin
            logic [DW-1:0] t;
            t = ref_rd(a);
            if (m[l]) t[l*8 +: 8] = d[l*8 +: 8];
            refm[a] = t;
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        bit seq_ok = 1;
        logic [DW-1:0] exp;
        exp = ref_rd(a);
        issue(1'b0, a, '0, '0);
        for (int n = 1; n <= RD; n++) begin
            if (mem_cs_n !== '0 || mem_oe_n !== 1'b0 || mem_we_n !== 1'b1 ||
                rsp_valid !== 1'b0 || mem_addr !== a) seq_ok = 0;
            @(negedge clk);
        end
        if (rsp_valid !== 1'b1 || mem_oe_n !== 1'b1 || mem_cs_n !== '1) seq_ok = 0;
        check(rsp_valid === 1'b1 && rsp_rdata === exp, req, "read data",
              {32'd0, rsp_rdata}, {32'd0, exp});
        @(negedge clk);
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) seq_ok = 0;
        check(seq_ok, "R3", "read strobe sequence and single pulse", {63'd0, seq_ok}, 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(mem_we_n && mem_oe_n && (&mem_cs_n) && !rsp_valid && req_ready, "R1",
              "strobes during reset", {59'd0, mem_we_n, mem_oe_n, mem_cs_n[2:0]}, 64'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_we_n && mem_oe_n && (&mem_cs_n) && !rsp_valid && req_ready, "R1",
              "strobes after reset", {59'd0, mem_we_n, mem_oe_n, mem_cs_n[2:0]}, 64'h1F);

        // Vector table: writes update the reference, reads compare against it (R5 masks).
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][54]) do_write(VEC[i][53:36], VEC[i][35:4], VEC[i][3:0], 1'b0, '0);
            else            do_read(VEC[i][53:36], "R5");
        end

        // R2: a read held valid during a write waits for the write to finish.
        do_write(18'h12345, 32'h0F0F0F0F, 4'hF, 1'b1, 18'h00000);
        do_read(18'h00000, "R2");
        // R8: read straight after a write returns memory data.
        do_read(18'h12345, "R8");

        // R1: reset in the middle of a read.
        issue(1'b0, 18'h3FFFF, '0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_we_n && mem_oe_n && (&mem_cs_n) && !rsp_valid && req_ready, "R1",
              "strobes after mid-read reset", {59'd0, mem_we_n, mem_oe_n, mem_cs_n[2:0]}, 64'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R1", "no response after aborted read",
              {62'd0, rsp_valid, req_ready}, 64'd1);
        do_read(18'h3FFFF, "R3");

        // R6/R7: memory model saw no address change in a write and no strobe overlap.
        check(viol == 0, "R6", "memory model rule violations", 64'(viol), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule